// File: doc/BRIEF.md
# Multi-cycle sticky right shifter

This block aligns a wide floating-point significand by shifting it right over a requested total distance. A single cycle moves the value by a bounded number of places, 16 by default. Longer distances take a series of cycles. Each bit that falls off the low end is OR-ed into the least significant position of the register. That position therefore carries the sticky information forward from one cycle to the next.

Rounding logic also needs to detect denormalization loss, which a plain OR reduction cannot show. Alongside the sticky bit, the block keeps two flags about the bits it discarded. One says that every discarded bit was one. The other says that every discarded bit was zero. Both are judged on the original bit values, never on the folded sticky position. The flags start at one when a request is accepted and are narrowed on every shift cycle. Their final values appear together with the shifted significand.

Requests enter through a valid/ready handshake, and results leave through another. A request is taken only when `in_valid` and `in_ready` are both high. The block works on one request at a time and shows `in_ready` low until its result has been handed over. A result is presented with `out_valid` and held, unchanged, for as long as `out_ready` stays low. It is released on the first cycle in which both are high. After that, the block accepts a new request.

Top module: `sticky_rshift`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A request is accepted only on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from acceptance until the result has been taken. Input activity in that interval does not alter the result in progress.
- R3: Let the clamped distance be dc = min(`in_dist`, 68). If dc = 0, `out_valid` is 1 right after the acceptance edge. Otherwise it rises after exactly ceil(dc/16) further rising edges, because no cycle shifts by more than 16 places.
- R4: `out_sig[67:1]` equals bits [67:1] of the accepted significand shifted right by dc, with zeros entering at bit 67.
- R5: `out_sig[0]` is the OR of the original bit that lands in position 0 and `out_sticky`.
- R6: `out_sticky` is 1 exactly when at least one discarded bit (the original bits [dc-1:0]) was 1.
- R7: `out_ones` is 1 exactly when every discarded original bit was 1. It is 1 when dc = 0.
- R8: `out_zero` is 1 exactly when every discarded original bit was 0. It is 1 when dc = 0.
- R9: If `in_dist` is 68 or more, all 68 original bits are discarded. `out_sig[67:1]` is zero, `out_sig[0]` equals the sticky bit, and the flags cover all 68 bits.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and all result outputs stay unchanged. After the edge where both are 1, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to accept a request |
| in_sig | input | 68 | Significand to be shifted |
| in_dist | input | 8 | Total right shift distance in places |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sig | output | 68 | Shifted significand, sticky folded into bit 0 |
| out_sticky | output | 1 | OR of all discarded bits |
| out_ones | output | 1 | All discarded bits were one |
| out_zero | output | 1 | All discarded bits were zero |

## Verification
Two things can happen in the same cycle. The final shift step discards the last original bits and moves the block to its result state, while `in_valid` is still high with a different significand and distance. The bench provokes this on every case. It keeps an intruding request asserted through the whole busy period and drops it only once the result appears. It then judges the outcome in three ways: the latency must match ceil(dc/16), the result must match the first payload, and `in_ready` must stay low. A further check targets the case where the folded sticky bit is 1 but an original bit discarded in an earlier or later cycle was 0. To provoke it, the bench sweeps every distance from 0 to 75 over patterns with isolated zeros and ones near the 16-bit step boundaries, and compares the flags against masks computed arithmetically.

// File: rtl/sticky_rshift_pkg.sv
package sticky_rshift_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2
  } shift_state_e;
endpackage

// File: rtl/sticky_step.sv
// One bounded right-shift step: moves the register by k places, folds the
// dropped bits into bit 0, and reduces the dropped original bits.
module sticky_step #(
  parameter int W    = 68,
  parameter int STEP = 16,
  parameter int KW   = 5
) (
  input  logic [W-1:0]  sig_in,
  input  logic          raw0_in,
  input  logic [KW-1:0] k,
  output logic [W-1:0]  sig_out,
  output logic          raw0_out,
  output logic          drop_any,
  output logic          drop_all
);
  logic [STEP-1:0] mask;
  logic [STEP-1:0] orig_low;
  logic [W-1:0]    moved;
  logic            fold;

  for (genvar i = 0; i < STEP; i++) begin : g_mask
    assign mask[i] = (k > KW'(i));
  end

  // bit 0 of sig_in may already hold folded sticky; raw0_in is the true bit
  assign orig_low = {sig_in[STEP-1:1], raw0_in} & mask;
  assign drop_any = |orig_low;
  assign drop_all = &(orig_low | ~mask);
  assign fold     = |(sig_in[STEP-1:0] & mask);

  assign moved    = sig_in >> k;
  assign sig_out  = {moved[W-1:1], moved[0] | fold};
  assign raw0_out = (k == '0) ? raw0_in : moved[0];
endmodule

// File: rtl/shift_dist_seq.sv
// Remaining-distance counter: clamps the request and hands out per-cycle
// amounts of at most STEP places.
module shift_dist_seq #(
  parameter int W      = 68,
  parameter int STEP   = 16,
  parameter int DIST_W = 8,
  parameter int RW     = 7,
  parameter int KW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DIST_W-1:0] dist_in,
  input  logic              advance,
  output logic [KW-1:0]     k,
  output logic              last,
  output logic              zero_len
);
  logic [RW-1:0] rem_q;
  logic [RW-1:0] dist_clamped;

  assign dist_clamped = (dist_in > DIST_W'(W)) ? RW'(W) : RW'(dist_in);
  assign zero_len     = (dist_in == '0);
  assign k            = (rem_q > RW'(STEP)) ? KW'(STEP) : rem_q[KW-1:0];
  assign last         = (rem_q <= RW'(STEP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= dist_clamped;
    end else if (advance) begin
      rem_q <= rem_q - RW'(k);
    end
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (k != '0) && (k <= KW'(STEP))); // R3
  AST_REM_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !load |=> rem_q < $past(rem_q)); // R3
endmodule

// File: rtl/sticky_rshift.sv
module sticky_rshift
  import sticky_rshift_pkg::*;
#(
  parameter int W      = 68,
  parameter int STEP   = 16,
  parameter int DIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_sig,
  input  logic [DIST_W-1:0] in_dist,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_sig,
  output logic              out_sticky,
  output logic              out_ones,
  output logic              out_zero
);
  localparam int RW = $clog2(W + 1);
  localparam int KW = $clog2(STEP + 1);

  shift_state_e state_q;
  logic [W-1:0] sig_q;
  logic         raw0_q;
  logic         sticky_q;
  logic         ones_q;
  logic         zeros_q;

  logic          accept;
  logic          advance;
  logic [KW-1:0] step_k;
  logic          step_last;
  logic          zero_len;
  logic [W-1:0]  step_sig;
  logic          step_raw0;
  logic          drop_any;
  logic          drop_all;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign accept    = in_valid && in_ready;
  assign advance   = (state_q == ST_BUSY);

  shift_dist_seq #(
    .W(W), .STEP(STEP), .DIST_W(DIST_W), .RW(RW), .KW(KW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .dist_in  (in_dist),
    .advance  (advance),
    .k        (step_k),
    .last     (step_last),
    .zero_len (zero_len)
  );

  sticky_step #(
    .W(W), .STEP(STEP), .KW(KW)
  ) u_step (
    .sig_in   (sig_q),
    .raw0_in  (raw0_q),
    .k        (step_k),
    .sig_out  (step_sig),
    .raw0_out (step_raw0),
    .drop_any (drop_any),
    .drop_all (drop_all)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sig_q    <= '0;
      raw0_q   <= 1'b0;
      sticky_q <= 1'b0;
      ones_q   <= 1'b1;
      zeros_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            sig_q    <= in_sig;
            raw0_q   <= in_sig[0];
            sticky_q <= 1'b0;
            ones_q   <= 1'b1;
            zeros_q  <= 1'b1;
            state_q  <= zero_len ? ST_HOLD : ST_BUSY;
          end
        end
        ST_BUSY: begin
          sig_q    <= step_sig;
          raw0_q   <= step_raw0;
          sticky_q <= sticky_q | drop_any;
          ones_q   <= ones_q & drop_all;
          zeros_q  <= zeros_q & ~drop_any;
          if (step_last) state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_sig    = sig_q;
  assign out_sticky = sticky_q;
  assign out_ones   = ones_q;
  assign out_zero   = zeros_q;

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sig)
      && $stable(out_sticky) && $stable(out_ones) && $stable(out_zero)); // R10
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid); // R10
  AST_STICKY_IN_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sticky |-> out_sig[0]); // R5
  AST_STICKY_VS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sticky != out_zero); // R8
endmodule

// File: tb/sticky_rshift_bench.sv
module sticky_rshift_bench;
  localparam int W  = 68;
  localparam int ST = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_sig = '0;
  logic [DW-1:0] in_dist = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  out_sig;
  logic          out_sticky;
  logic          out_ones;
  logic          out_zero;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sticky_rshift u_sticky_rshift (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_sig(in_sig), .in_dist(in_dist),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sig(out_sig), .out_sticky(out_sticky),
    .out_ones(out_ones), .out_zero(out_zero)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [W-1:0] p, input int d, input int hold);
    int dc;
    int lat;
    int exp_lat;
    logic [W-1:0] full, mask, disc, eout;
    logic es, eo, ez;
    dc   = (d > W) ? W : d;
    full = (dc >= W) ? '0 : (p >> dc);
    mask = (dc == 0) ? '0 : ({W{1'b1}} >> (W - dc));
    disc = p & mask;
    es   = |disc;
    eo   = (disc == mask);
    ez   = (disc == '0);
    eout = {full[W-1:1], full[0] | es};
    exp_lat = (dc + ST - 1) / ST;

    @(negedge clk);
    chk(in_ready == 1'b1, "R2 idle ready", W'(in_ready), W'(1));
    in_valid = 1'b1; in_sig = p; in_dist = DW'(d);
    @(posedge clk);
    @(negedge clk);
    // intruding request held while busy must be ignored (R2)
    in_sig = ~p; in_dist = DW'(3);
    lat = 0;
    while (!out_valid && lat < 20) begin
      chk(in_ready == 1'b0, "R2 busy not ready", W'(in_ready), W'(0));
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    chk(lat == exp_lat, "R3 latency", W'(lat), W'(exp_lat));
    if (d >= W) chk(out_sig == eout, "R9 full discard", out_sig, eout);
    chk(out_sig[W-1:1] == eout[W-1:1], "R4 shifted field", out_sig, eout);
    chk(out_sig[0] == eout[0], "R5 lsb", W'(out_sig[0]), W'(eout[0]));
    chk(out_sticky == es, "R6 sticky", W'(out_sticky), W'(es));
    chk(out_ones == eo, "R7 all ones", W'(out_ones), W'(eo));
    chk(out_zero == ez, "R8 all zero", W'(out_zero), W'(ez));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid && out_sig == eout && out_sticky == es && out_ones == eo
          && out_zero == ez, "R10 hold stable", out_sig, eout);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready && !out_valid, "R10 release", W'({in_ready, out_valid}), W'(2));
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] pats [10];
    logic [63:0]  x;
    x = 64'h9E37_79B9_7F4A_7C15;
    pats[0] = {W{1'b1}};
    pats[1] = '0;
    pats[2] = {(W/2){2'b10}};
    pats[3] = {(W/2){2'b01}};
    pats[4] = {W{1'b1}} ^ (W'(1) << 16);
    pats[5] = {W{1'b1}} ^ W'(1);
    pats[6] = (W'(1) << 33) | (W'(1) << 15);
    pats[7] = W'(1) << (W - 1);
    for (int i = 8; i < 10; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      pats[i] = {x[3:0], x};
    end

    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset ready", W'(in_ready), W'(1));
    chk(out_valid == 1'b0, "R1 reset valid", W'(out_valid), W'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R1 after release", W'({in_ready, out_valid}), W'(2));

    for (int pi = 0; pi < 10; pi++) begin
      for (int d = 0; d <= 75; d++) begin
        run_case(pats[pi], d, d % 3);
      end
    end
    run_case(pats[8], 255, 2);
    run_case(pats[4], 200, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule